// File: doc/BRIEF.md
# Command-Response Condition Code Arbiter

This block sits in a peripheral attachment that serves several device units behind one controller. Each time the host strobes an immediate I/O command (unit number, function, modifier, control-block address and an interface parity flag), the block answers with one 3-bit condition code. It checks all of its conditions in parallel: unit not attached, unit busy, reset pending, bad parameters, parity error, controller busy and accepted. It then reports the lowest-numbered condition that the command's class is allowed to report.

The block also keeps the state behind those answers. Each unit has a busy flag. It is raised when a cycle-steal start is accepted and lowered when the host acknowledges that unit's interrupt. A controller-wide reset-pending window is opened by a synchronous reset or by an accepted unit-reset command, and it closes by itself with no interrupt. A controller hold window follows every accepted cycle-steal start. An accepted cycle-steal start also raises a one-cycle control-block fetch request. A rejected start never does. An accepted read-ID command returns the unit's identification word.

Top module: `ccode_arbiter`

## Requirements
- R1: A response appears exactly one clock edge after a command strobe, with `rsp_valid_o` high for that one cycle. The code is driven as `{cc_even_o, cc_carry_o, cc_ovfl_o}` = code bits {2,1,0}. On cycles without a response, and after reset, every output is 0.
- R2: A command to a unit whose bit in `unit_attached_i` is 0 returns code 0, whatever its class or other conditions.
- R3: Function 0 (prepare), 1 (unit reset) and 2 (read ID) form the direct class, which may return only codes 0, 5 and 7. Functions 8 to 11 are cycle-steal starts, which may return codes 0, 1, 2, 3, 5, 6 and 7. Every other function is unknown and returns code 3 when the unit is attached. Code 4 is never returned.
- R4: An accepted cycle-steal start (code 7) makes its unit busy. A later cycle-steal start to that unit returns code 1 until `irq_ack_i` is seen with that unit on `irq_ack_unit_i`. An acknowledge to a unit that is not busy has no effect.
- R5: For RST_CYC edges after a synchronous reset, and again after an accepted unit-reset command, a cycle-steal start to a unit that is not busy returns code 2. The window then closes by itself.
- R6: A cycle-steal start whose control-block address has bit 0 set, or whose modifier is greater than 1, returns code 3 unless a higher-priority code applies, and raises no fetch.
- R7: A command with `cmd_par_err_i` high returns code 5 when no lower-numbered allowed code applies.
- R8: For HOLD_CYC edges after an accepted cycle-steal start, a cycle-steal start to a different unit returns code 6 when no lower-numbered code applies. The same unit is not affected.
- R9: An accepted read-ID command returns ID_BASE plus the unit number on `rsp_data_o`. Every other response returns 0 there.
- R10: An accepted cycle-steal start raises `fetch_o` in the response cycle, with the command's control-block address on `fetch_addr_o`.
- R11: When several conditions hold at once, the lowest-numbered allowed code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_unit_i | input | UNIT_W | Addressed unit |
| cmd_func_i | input | 4 | Function code |
| cmd_mod_i | input | 4 | Modifier |
| cmd_blk_addr_i | input | ADDR_W | Control-block byte address |
| cmd_par_err_i | input | 1 | Parity error seen on the command transfer |
| unit_attached_i | input | 2**UNIT_W | One bit per unit, 1 = attached |
| irq_ack_i | input | 1 | Host accepted an interrupt |
| irq_ack_unit_i | input | UNIT_W | Unit whose interrupt was accepted |
| rsp_valid_o | output | 1 | Response valid |
| cc_even_o | output | 1 | Code bit 2 |
| cc_carry_o | output | 1 | Code bit 1 |
| cc_ovfl_o | output | 1 | Code bit 0 |
| rsp_data_o | output | DATA_W | Immediate data returned (identification word) |
| fetch_o | output | 1 | Control-block fetch request |
| fetch_addr_o | output | ADDR_W | Control-block address to fetch |

## Verification
Every response, including its code, data and fetch request, is due on the first rising edge after the strobe. State changes made at that edge (busy, reset-pending, hold) are first seen by a command strobed for the next edge. The bench drives inputs and samples outputs on falling edges, so each comparison sits half a cycle after the edge that produced the response. A behavioural model advances at every rising edge from the same inputs and is compared with the design at every falling edge. This covers cycles with no command, where all outputs must be 0.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef logic [2:0] ccode_t;

  typedef enum logic [1:0] {
    CLS_DIRECT  = 2'd0,
    CLS_CSTEAL  = 2'd1,
    CLS_UNKNOWN = 2'd2
  } cmd_class_e;

  localparam logic [3:0] FN_PREPARE    = 4'h0;
  localparam logic [3:0] FN_UNIT_RESET = 4'h1;
  localparam logic [3:0] FN_READ_ID    = 4'h2;
  localparam logic [3:0] FN_CS_FIRST   = 4'h8;
  localparam logic [3:0] FN_CS_LAST    = 4'hB;

  localparam ccode_t CC_NOT_ATT   = 3'd0;
  localparam ccode_t CC_BUSY      = 3'd1;
  localparam ccode_t CC_RST_PEND  = 3'd2;
  localparam ccode_t CC_REJECT    = 3'd3;
  localparam ccode_t CC_UNUSED    = 3'd4;
  localparam ccode_t CC_PARITY    = 3'd5;
  localparam ccode_t CC_CTRL_BUSY = 3'd6;
  localparam ccode_t CC_ACCEPT    = 3'd7;

  // Allowed code positions per class, bit n = code n may be reported
  localparam logic [7:0] MASK_DIRECT  = 8'b1010_0001;
  localparam logic [7:0] MASK_CSTEAL  = 8'b1110_1111;
  localparam logic [7:0] MASK_UNKNOWN = 8'b0010_1001;

  function automatic cmd_class_e classify(input logic [3:0] fn);
    if (fn == FN_PREPARE || fn == FN_UNIT_RESET || fn == FN_READ_ID)
      return CLS_DIRECT;
    else if (fn >= FN_CS_FIRST && fn <= FN_CS_LAST)
      return CLS_CSTEAL;
    else
      return CLS_UNKNOWN;
  endfunction

  function automatic logic [7:0] class_mask(input cmd_class_e cls);
    case (cls)
      CLS_DIRECT: return MASK_DIRECT;
      CLS_CSTEAL: return MASK_CSTEAL;
      default:    return MASK_UNKNOWN;
    endcase
  endfunction

  // Lowest set bit wins: code 0 has the highest priority
  function automatic ccode_t lowest_set(input logic [7:0] v);
    ccode_t r;
    r = CC_ACCEPT;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) r = ccode_t'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/cc_cmd_decode.sv
module cc_cmd_decode
  import cc_pkg::*;
(
  input  logic [3:0] func_i,
  input  logic [3:0] mod_i,
  input  logic       blk_addr_lsb_i,
  output cmd_class_e class_o,
  output logic       bad_param_o
);

  always_comb begin
    class_o = classify(func_i);
    case (class_o)
      CLS_DIRECT: bad_param_o = 1'b0;
      CLS_CSTEAL: bad_param_o = blk_addr_lsb_i | (mod_i > 4'd1);
      default:    bad_param_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cc_countdown.sv
module cc_countdown #(
  parameter int unsigned LOAD_VAL   = 8,
  parameter bit          ARM_ON_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  output logic active_o
);

  localparam int unsigned CNT_W = $clog2(LOAD_VAL + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)
      cnt_q <= ARM_ON_RST ? CNT_W'(LOAD_VAL) : '0;
    else if (load_i)
      cnt_q <= CNT_W'(LOAD_VAL);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/cc_busy_tracker.sv
module cc_busy_tracker #(
  parameter int unsigned UNIT_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     set_i,
  input  logic [UNIT_W-1:0]        set_unit_i,
  input  logic                     clr_i,
  input  logic [UNIT_W-1:0]        clr_unit_i,
  output logic [(1<<UNIT_W)-1:0]   busy_o
);

  localparam int unsigned N_UNITS = 1 << UNIT_W;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    logic busy_q;
    always_ff @(posedge clk_i) begin
      if (rst_i)
        busy_q <= 1'b0;
      else if (set_i && set_unit_i == UNIT_W'(g))
        busy_q <= 1'b1;
      else if (clr_i && clr_unit_i == UNIT_W'(g))
        busy_q <= 1'b0;
    end
    assign busy_o[g] = busy_q;
  end

endmodule

// File: rtl/cc_code_select.sv
module cc_code_select
  import cc_pkg::*;
(
  input  cmd_class_e  class_i,
  input  logic [7:0]  cond_i,
  output logic [7:0]  mask_o,
  output ccode_t      code_o
);

  always_comb begin
    mask_o = class_mask(class_i);
    code_o = lowest_set(cond_i & mask_o);
  end

endmodule

// File: rtl/ccode_arbiter.sv
module ccode_arbiter
  import cc_pkg::*;
#(
  parameter int unsigned UNIT_W   = 2,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned RST_CYC  = 12,
  parameter int unsigned HOLD_CYC = 5,
  parameter logic [DATA_W-1:0] ID_BASE = 16'h4A60
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    cmd_valid_i,
  input  logic [UNIT_W-1:0]       cmd_unit_i,
  input  logic [3:0]              cmd_func_i,
  input  logic [3:0]              cmd_mod_i,
  input  logic [ADDR_W-1:0]       cmd_blk_addr_i,
  input  logic                    cmd_par_err_i,
  input  logic [(1<<UNIT_W)-1:0]  unit_attached_i,
  input  logic                    irq_ack_i,
  input  logic [UNIT_W-1:0]       irq_ack_unit_i,
  output logic                    rsp_valid_o,
  output logic                    cc_even_o,
  output logic                    cc_carry_o,
  output logic                    cc_ovfl_o,
  output logic [DATA_W-1:0]       rsp_data_o,
  output logic                    fetch_o,
  output logic [ADDR_W-1:0]       fetch_addr_o
);

  localparam int unsigned N_UNITS = 1 << UNIT_W;

  cmd_class_e          cmd_class;
  logic                bad_param;
  logic [N_UNITS-1:0]  unit_busy_vec;
  logic                rst_pending;
  logic                ctrl_active;
  logic [UNIT_W-1:0]   hold_unit_q;
  logic                ctrl_conflict;
  logic [7:0]          cond_vec;
  logic [7:0]          active_mask;
  ccode_t              sel_code;
  logic                cmd_accept;
  logic                cs_accept;
  logic                ureset_accept;
  logic                rdid_accept;

  cc_cmd_decode u_decode (
    .func_i         (cmd_func_i),
    .mod_i          (cmd_mod_i),
    .blk_addr_lsb_i (cmd_blk_addr_i[0]),
    .class_o        (cmd_class),
    .bad_param_o    (bad_param)
  );

  assign ctrl_conflict = ctrl_active && (hold_unit_q != cmd_unit_i);

  always_comb begin
    cond_vec               = '0;
    cond_vec[CC_NOT_ATT]   = ~unit_attached_i[cmd_unit_i];
    cond_vec[CC_BUSY]      = unit_busy_vec[cmd_unit_i];
    cond_vec[CC_RST_PEND]  = rst_pending;
    cond_vec[CC_REJECT]    = bad_param;
    cond_vec[CC_UNUSED]    = 1'b0;
    cond_vec[CC_PARITY]    = cmd_par_err_i;
    cond_vec[CC_CTRL_BUSY] = ctrl_conflict;
    cond_vec[CC_ACCEPT]    = 1'b1;
  end

  cc_code_select u_select (
    .class_i (cmd_class),
    .cond_i  (cond_vec),
    .mask_o  (active_mask),
    .code_o  (sel_code)
  );

  assign cmd_accept    = cmd_valid_i && (sel_code == CC_ACCEPT);
  assign cs_accept     = cmd_accept && (cmd_class == CLS_CSTEAL);
  assign ureset_accept = cmd_accept && (cmd_func_i == FN_UNIT_RESET);
  assign rdid_accept   = cmd_accept && (cmd_func_i == FN_READ_ID);

  cc_busy_tracker #(.UNIT_W(UNIT_W)) u_busy (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .set_i      (cs_accept),
    .set_unit_i (cmd_unit_i),
    .clr_i      (irq_ack_i),
    .clr_unit_i (irq_ack_unit_i),
    .busy_o     (unit_busy_vec)
  );

  cc_countdown #(.LOAD_VAL(RST_CYC), .ARM_ON_RST(1'b1)) u_rst_pend (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (ureset_accept),
    .active_o (rst_pending)
  );

  cc_countdown #(.LOAD_VAL(HOLD_CYC), .ARM_ON_RST(1'b0)) u_ctrl_hold (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (cs_accept),
    .active_o (ctrl_active)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)
      hold_unit_q <= '0;
    else if (cs_accept)
      hold_unit_q <= cmd_unit_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !cmd_valid_i) begin
      rsp_valid_o  <= 1'b0;
      cc_even_o    <= 1'b0;
      cc_carry_o   <= 1'b0;
      cc_ovfl_o    <= 1'b0;
      rsp_data_o   <= '0;
      fetch_o      <= 1'b0;
      fetch_addr_o <= '0;
    end else begin
      rsp_valid_o  <= 1'b1;
      cc_even_o    <= sel_code[2];
      cc_carry_o   <= sel_code[1];
      cc_ovfl_o    <= sel_code[0];
      rsp_data_o   <= rdid_accept ? (ID_BASE + DATA_W'(cmd_unit_i)) : '0;
      fetch_o      <= cs_accept;
      fetch_addr_o <= cs_accept ? cmd_blk_addr_i : '0;
    end
  end

endmodule

// File: rtl/cc_arbiter_chk.sv
module cc_arbiter_chk
  import cc_pkg::*;
#(
  parameter int unsigned UNIT_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    cmd_valid_i,
  input logic [UNIT_W-1:0]       cmd_unit_i,
  input logic [(1<<UNIT_W)-1:0]  unit_attached_i,
  input cmd_class_e              cmd_class,
  input logic                    cs_accept,
  input logic                    rsp_valid_o,
  input logic                    cc_even_o,
  input logic                    cc_carry_o,
  input logic                    cc_ovfl_o,
  input logic                    fetch_o
);

  logic [2:0] out_code;
  logic       att_now;
  assign out_code = {cc_even_o, cc_carry_o, cc_ovfl_o};
  assign att_now  = unit_attached_i[cmd_unit_i];

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_valid_i |=> rsp_valid_o); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmd_valid_i |=> !rsp_valid_o); // R1
  AST_NOT_ATTACHED_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_valid_i && !att_now) |=> (out_code == 3'd0)); // R2
  AST_CODE4_NEVER: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o |-> (out_code != 3'd4)); // R3
  AST_DIRECT_MASK: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_valid_i && cmd_class == CLS_DIRECT) |=>
      (out_code == 3'd0 || out_code == 3'd5 || out_code == 3'd7)); // R3
  AST_REJECT_NO_FETCH: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_valid_o && out_code == 3'd3) |-> !fetch_o); // R6
  AST_FETCH_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    fetch_o |-> (rsp_valid_o && out_code == 3'd7)); // R10
  AST_FETCH_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    cs_accept |=> fetch_o); // R10

endmodule

bind ccode_arbiter cc_arbiter_chk #(.UNIT_W(UNIT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_i           (rst_i),
  .cmd_valid_i     (cmd_valid_i),
  .cmd_unit_i      (cmd_unit_i),
  .unit_attached_i (unit_attached_i),
  .cmd_class       (cmd_class),
  .cs_accept       (cs_accept),
  .rsp_valid_o     (rsp_valid_o),
  .cc_even_o       (cc_even_o),
  .cc_carry_o      (cc_carry_o),
  .cc_ovfl_o       (cc_ovfl_o),
  .fetch_o         (fetch_o)
);

// File: tb/tb_ccode_arbiter.sv
module tb_ccode_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int UW    = 2;
  localparam int NU    = 1 << UW;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int RSTC  = 12;
  localparam int HOLDC = 5;
  localparam logic [DW-1:0] IDB = 16'h4A60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [UW-1:0] cmd_unit = '0;
  logic [3:0]    cmd_func = '0;
  logic [3:0]    cmd_mod = '0;
  logic [AW-1:0] cmd_blk = '0;
  logic          cmd_par = 1'b0;
  logic [NU-1:0] attached = 4'b0111;
  logic          irq_ack = 1'b0;
  logic [UW-1:0] ack_unit = '0;

  logic          rsp_valid, cc_e, cc_c, cc_o, fetch;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] fetch_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccode_arbiter #(
    .UNIT_W(UW), .ADDR_W(AW), .DATA_W(DW),
    .RST_CYC(RSTC), .HOLD_CYC(HOLDC), .ID_BASE(IDB)
  ) dut (
    .clk_i(clk), .rst_i(rst),
    .cmd_valid_i(cmd_valid), .cmd_unit_i(cmd_unit), .cmd_func_i(cmd_func),
    .cmd_mod_i(cmd_mod), .cmd_blk_addr_i(cmd_blk), .cmd_par_err_i(cmd_par),
    .unit_attached_i(attached), .irq_ack_i(irq_ack), .irq_ack_unit_i(ack_unit),
    .rsp_valid_o(rsp_valid), .cc_even_o(cc_e), .cc_carry_o(cc_c), .cc_ovfl_o(cc_o),
    .rsp_data_o(rsp_data), .fetch_o(fetch), .fetch_addr_o(fetch_addr)
  );

  // Behavioural reference model
  int            m_rp, m_hold, m_hold_unit;
  bit            m_busy [NU];
  bit            e_valid, e_fetch;
  int            e_code;
  logic [DW-1:0] e_data;
  logic [AW-1:0] e_faddr;

  always @(posedge clk) begin : model
    int  code, u, fn;
    bit  acc_cs, acc_ur;
    if (rst) begin
      m_rp = RSTC; m_hold = 0; m_hold_unit = 0;
      for (int i = 0; i < NU; i++) m_busy[i] = 1'b0;
      e_valid = 0; e_code = 0; e_data = '0; e_fetch = 0; e_faddr = '0;
    end else begin
      acc_cs = 0; acc_ur = 0; code = 0;
      u = int'(cmd_unit); fn = int'(cmd_func);
      e_valid = cmd_valid; e_code = 0; e_data = '0; e_fetch = 0; e_faddr = '0;
      if (cmd_valid) begin
        if (!attached[u]) code = 0;
        else if (fn <= 2) code = cmd_par ? 5 : 7;
        else if (fn >= 8 && fn <= 11) begin
          if (m_busy[u]) code = 1;
          else if (m_rp > 0) code = 2;
          else if (cmd_blk[0] || cmd_mod > 1) code = 3;
          else if (cmd_par) code = 5;
          else if (m_hold > 0 && u != m_hold_unit) code = 6;
          else code = 7;
        end else code = 3;
        e_code = code;
        if (code == 7 && fn == 2) e_data = IDB + DW'(u);
        if (code == 7 && fn >= 8) begin e_fetch = 1; e_faddr = cmd_blk; acc_cs = 1; end
        if (code == 7 && fn == 1) acc_ur = 1;
      end
      if (m_rp > 0) m_rp--;
      if (m_hold > 0) m_hold--;
      if (irq_ack) m_busy[int'(ack_unit)] = 1'b0;
      if (acc_cs) begin m_busy[u] = 1'b1; m_hold = HOLDC; m_hold_unit = u; end
      if (acc_ur) m_rp = RSTC;
    end
  end

  int    n_cmp = 0, n_bad = 0;
  bit    cmp_en = 0, done = 0;
  string cur_req = "R1";

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      n_cmp++;
      if (rsp_valid !== e_valid || {cc_e, cc_c, cc_o} !== 3'(e_code) ||
          rsp_data !== e_data || fetch !== e_fetch || fetch_addr !== e_faddr) begin
        n_bad++;
        $display("FAIL %s: got v=%0b cc=%0d data=%h fetch=%0b addr=%h, expected v=%0b cc=%0d data=%h fetch=%0b addr=%h",
                 cur_req, rsp_valid, {cc_e, cc_c, cc_o}, rsp_data, fetch, fetch_addr,
                 e_valid, e_code, e_data, e_fetch, e_faddr);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic issue(input int u, input int fn, input int md, input int addr, input bit par);
    cmd_valid = 1'b1; cmd_unit = UW'(u); cmd_func = 4'(fn);
    cmd_mod = 4'(md); cmd_blk = AW'(addr); cmd_par = par;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_par = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input int u);
    irq_ack = 1'b1; ack_unit = UW'(u);
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cmp_en = 1;
    cur_req = "R1 reset state";
    idle(2);
    rst = 1'b0;
    cur_req = "R5 pending after reset"; issue(0, 8, 0, 'h100, 0);
    cur_req = "R9 read id";             issue(1, 2, 0, 0, 0);
    cur_req = "R3 direct while pending"; issue(2, 0, 0, 0, 0);
    cur_req = "R1 idle";                idle(14);
    cur_req = "R2 not attached";        issue(3, 8, 0, 'h10, 0); issue(3, 2, 0, 0, 1);
    cur_req = "R10 accept fetch";       issue(0, 9, 0, 'h200, 0);
    cur_req = "R4 busy";                issue(0, 8, 0, 'h300, 0);
    cur_req = "R8 ctrl busy";           issue(1, 8, 0, 'h400, 0);
    cur_req = "R11 busy over parity";   issue(0, 10, 0, 'h10, 1);
    idle(6);
    cur_req = "R3 direct on busy unit"; issue(0, 2, 0, 0, 0);
    cur_req = "R4 ack idle unit";       ack(2); issue(2, 8, 0, 'h20, 0);
    cur_req = "R8 same unit";           issue(2, 8, 0, 'h22, 0);
    cur_req = "R8 other unit";          issue(1, 8, 0, 'h24, 0);
    idle(6);
    cur_req = "R6 odd address";         issue(1, 8, 0, 'h31, 0);
    cur_req = "R6 bad modifier";        issue(1, 8, 2, 'h30, 0);
    cur_req = "R11 reject over parity"; issue(1, 8, 0, 'h33, 1);
    cur_req = "R7 parity cs";           issue(1, 8, 0, 'h30, 1);
    cur_req = "R7 parity direct";       issue(1, 0, 0, 0, 1);
    cur_req = "R3 unknown function";    issue(1, 5, 0, 0, 0); issue(1, 15, 0, 0, 1);
    cur_req = "R4 release by ack";      ack(0); issue(0, 11, 1, 'h40, 0);
    cur_req = "R5 rearm by unit reset"; issue(1, 1, 0, 0, 0); issue(1, 8, 0, 'h50, 0);
    idle(13);
    cur_req = "R11 mixed traffic";
    for (int k = 0; k < 400; k++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      cmd_valid = ($urandom_range(0, 3) != 0);
      cmd_unit  = UW'($urandom_range(0, NU - 1));
      cmd_func  = (pick < 3) ? 4'(pick) : (pick < 8) ? 4'(pick + 5) : (pick == 8) ? 4'h5 : 4'hD;
      if (pick == 1 && $urandom_range(0, 3) != 0) cmd_func = 4'h8;
      cmd_mod   = 4'($urandom_range(0, 2));
      cmd_blk   = AW'($urandom);
      cmd_par   = ($urandom_range(0, 7) == 0);
      irq_ack   = ($urandom_range(0, 4) == 0);
      ack_unit  = UW'($urandom_range(0, NU - 1));
      @(negedge clk);
    end
    cmd_valid = 1'b0; irq_ack = 1'b0; cmd_par = 1'b0;
    idle(3);
    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      report();
    end
    $finish;
  end

endmodule